// File: doc/BRIEF.md
# Stream Gate Substitution Stage

This stage sits in a sample stream whose beats each carry a small gate field in their least significant bits, with sample data above it. Every beat passes through one register stage. The gate field on the way out is chosen by a two-bit mode held in a control register. The mode can keep the arriving gate, replace it with an external user gate level, or combine the two with a bitwise AND. Sample bits, the end-of-packet flag and the sideband bits are not modified.

Both stream sides use valid/ready handshakes. A beat moves when valid and ready are both high at a rising clock edge. The input ready is high whenever the output register is empty or the downstream side is ready, so full throughput is kept and nothing is lost or duplicated under back-pressure. While the output is stalled, the held beat stays frozen, and the upstream side must keep its beat steady until it is accepted. The user gate level is a plain input and is read at the edge that accepts a beat.

The mode is written over a lightweight memory-mapped slave port that uses separate address, write data, write response, read address and read data channels.

Top module: `gate_sub_stage`

## Requirements
- R1: After reset the mode field is 00, the output holds no beat (`out_tvalid` low), and a read of offset 0x0 returns zero.
- R2: With mode 00, output bits [1:0] of a beat equal the input bits [1:0] of that beat.
- R3: With mode 01, output bits [1:0] of a beat equal `usr_gate`.
- R4: With mode 10 or 11, output bits [1:0] of a beat equal the bitwise AND of input bits [1:0] and `usr_gate`.
- R5: Output bits [31:2], `out_tlast` and `out_tuser` equal those of the accepted input beat. A beat accepted at one edge is presented on the output from that edge on.
- R6: `in_tready` is high exactly when the output register is empty or `out_tready` is high. While `out_tvalid` is high and `out_tready` is low, every output stays stable. Beats leave in arrival order, with none lost or repeated.
- R7: The control word at offset 0x0 holds the mode in bits [1:0]. A write with byte strobe bit 0 set loads bits [1:0] of the write data. A write with that strobe bit clear leaves the mode unchanged. Bits [31:2] always read as zero.
- R8: A write to any other word offset changes nothing, and a read from any other word offset returns zero. Every write response and read response is OKAY (00).
- R9: A new mode applies to beats accepted at later edges than the write handshake. A beat already in the output register keeps the gate it was given.
- R10: `usr_gate` is sampled only at the edge where the beat is accepted. Values it takes while the beat waits for `in_tready` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_awaddr | input | ADDR_W | Write address (byte) |
| ctl_awvalid | input | 1 | Write address valid |
| ctl_awready | output | 1 | Write address ready |
| ctl_wdata | input | 32 | Write data |
| ctl_wstrb | input | 4 | Write byte strobes |
| ctl_wvalid | input | 1 | Write data valid |
| ctl_wready | output | 1 | Write data ready |
| ctl_bresp | output | 2 | Write response, always 00 |
| ctl_bvalid | output | 1 | Write response valid |
| ctl_bready | input | 1 | Write response ready |
| ctl_araddr | input | ADDR_W | Read address (byte) |
| ctl_arvalid | input | 1 | Read address valid |
| ctl_arready | output | 1 | Read address ready |
| ctl_rdata | output | 32 | Read data |
| ctl_rresp | output | 2 | Read response, always 00 |
| ctl_rvalid | output | 1 | Read data valid |
| ctl_rready | input | 1 | Read data ready |
| usr_gate | input | 2 | External user gate level |
| in_tdata | input | DATA_W | Input beat; bits [1:0] are the gate |
| in_tlast | input | 1 | Input end-of-packet flag |
| in_tuser | input | USER_W | Input sideband bits |
| in_tvalid | input | 1 | Input beat valid |
| in_tready | output | 1 | Input beat ready |
| out_tdata | output | DATA_W | Output beat with the chosen gate |
| out_tlast | output | 1 | Output end-of-packet flag |
| out_tuser | output | USER_W | Output sideband bits |
| out_tvalid | output | 1 | Output beat valid |
| out_tready | input | 1 | Output beat ready |

## Verification
The properties assume the upstream source follows the handshake rules. A beat it offers stays unchanged until it is accepted, and the downstream ready and the user gate are settled before each rising edge. The bench drives every input on the falling edge. It keeps each beat and its valid steady until it sees `in_tready`, and it changes `usr_gate` only while a beat is still waiting. Control writes are issued while the stream is idle, or while the one beat in flight is parked in the output register, so the mode used by each beat is never ambiguous.

// File: rtl/gsub_pkg.sv
package gsub_pkg;
  localparam int CTL_W  = 32;
  localparam int GATE_W = 2;
  localparam int STRB_W = CTL_W / 8;

  typedef enum logic [GATE_W-1:0] {
    GM_KEEP  = 2'b00,
    GM_USER  = 2'b01,
    GM_AND_A = 2'b10,
    GM_AND_B = 2'b11
  } gate_mode_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/gsub_ctrl.sv
module gsub_ctrl
  import gsub_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   awaddr,
  input  logic                awvalid,
  output logic                awready,
  input  logic [CTL_W-1:0]    wdata,
  input  logic [STRB_W-1:0]   wstrb,
  input  logic                wvalid,
  output logic                wready,
  output logic [1:0]          bresp,
  output logic                bvalid,
  input  logic                bready,
  input  logic [ADDR_W-1:0]   araddr,
  input  logic                arvalid,
  output logic                arready,
  output logic [CTL_W-1:0]    rdata,
  output logic [1:0]          rresp,
  output logic                rvalid,
  input  logic                rready,
  output gate_mode_e          mode
);
  localparam int WORD_LSB = $clog2(STRB_W);

  logic       wr_go;
  logic       rd_go;
  logic       wr_hit;
  logic       rd_hit;
  gate_mode_e mode_q;
  logic       bvalid_q;
  logic       rvalid_q;
  logic [CTL_W-1:0] rdata_q;

  // write address and data are taken together, one response outstanding
  assign wr_go   = awvalid && wvalid && !bvalid_q;
  assign awready = wr_go;
  assign wready  = wr_go;
  assign rd_go   = arvalid && !rvalid_q;
  assign arready = !rvalid_q;

  assign wr_hit = (awaddr[ADDR_W-1:WORD_LSB] == '0);
  assign rd_hit = (araddr[ADDR_W-1:WORD_LSB] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= GM_KEEP;
      bvalid_q <= 1'b0;
    end else begin
      if (wr_go && wr_hit && wstrb[0])
        mode_q <= gate_mode_e'(wdata[GATE_W-1:0]);
      if (wr_go)
        bvalid_q <= 1'b1;
      else if (bready)
        bvalid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (rd_go) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_hit ? {{(CTL_W-GATE_W){1'b0}}, mode_q} : '0;
      end else if (rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign bvalid = bvalid_q;
  assign bresp  = RESP_OKAY;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;
  assign rresp  = RESP_OKAY;
  assign mode   = mode_q;
endmodule

// File: rtl/gsub_gate_mux.sv
module gsub_gate_mux
  import gsub_pkg::*;
(
  input  gate_mode_e        mode,
  input  logic [GATE_W-1:0] beat_gate,
  input  logic [GATE_W-1:0] ext_gate,
  output logic [GATE_W-1:0] new_gate
);
  for (genvar b = 0; b < GATE_W; b++) begin : g_bit
    always_comb begin
      unique case (mode)
        GM_KEEP:  new_gate[b] = beat_gate[b];
        GM_USER:  new_gate[b] = ext_gate[b];
        default:  new_gate[b] = beat_gate[b] & ext_gate[b];
      endcase
    end
  end
endmodule

// File: rtl/gsub_slice.sv
module gsub_slice #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PAY_W-1:0] s_pay,
  input  logic             s_valid,
  output logic             s_ready,
  output logic [PAY_W-1:0] m_pay,
  output logic             m_valid,
  input  logic             m_ready
);
  logic             full_q;
  logic [PAY_W-1:0] pay_q;
  logic             take;

  assign s_ready = !full_q || m_ready;
  assign take    = s_valid && s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
    end else if (m_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) pay_q <= s_pay;
  end

  assign m_valid = full_q;
  assign m_pay   = pay_q;
endmodule

// File: rtl/gate_sub_stage.sv
module gate_sub_stage
  import gsub_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int USER_W = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ctl_awaddr,
  input  logic              ctl_awvalid,
  output logic              ctl_awready,
  input  logic [31:0]       ctl_wdata,
  input  logic [3:0]        ctl_wstrb,
  input  logic              ctl_wvalid,
  output logic              ctl_wready,
  output logic [1:0]        ctl_bresp,
  output logic              ctl_bvalid,
  input  logic              ctl_bready,
  input  logic [ADDR_W-1:0] ctl_araddr,
  input  logic              ctl_arvalid,
  output logic              ctl_arready,
  output logic [31:0]       ctl_rdata,
  output logic [1:0]        ctl_rresp,
  output logic              ctl_rvalid,
  input  logic              ctl_rready,
  input  logic [1:0]        usr_gate,
  input  logic [DATA_W-1:0] in_tdata,
  input  logic              in_tlast,
  input  logic [USER_W-1:0] in_tuser,
  input  logic              in_tvalid,
  output logic              in_tready,
  output logic [DATA_W-1:0] out_tdata,
  output logic              out_tlast,
  output logic [USER_W-1:0] out_tuser,
  output logic              out_tvalid,
  input  logic              out_tready
);
  localparam int PAY_W = USER_W + 1 + DATA_W;

  gate_mode_e        sel_q;
  logic [GATE_W-1:0] gate_new;
  logic [PAY_W-1:0]  pay_in;
  logic [PAY_W-1:0]  pay_out;

  gsub_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .awaddr  (ctl_awaddr),
    .awvalid (ctl_awvalid),
    .awready (ctl_awready),
    .wdata   (ctl_wdata),
    .wstrb   (ctl_wstrb),
    .wvalid  (ctl_wvalid),
    .wready  (ctl_wready),
    .bresp   (ctl_bresp),
    .bvalid  (ctl_bvalid),
    .bready  (ctl_bready),
    .araddr  (ctl_araddr),
    .arvalid (ctl_arvalid),
    .arready (ctl_arready),
    .rdata   (ctl_rdata),
    .rresp   (ctl_rresp),
    .rvalid  (ctl_rvalid),
    .rready  (ctl_rready),
    .mode    (sel_q)
  );

  gsub_gate_mux u_mux (
    .mode      (sel_q),
    .beat_gate (in_tdata[GATE_W-1:0]),
    .ext_gate  (usr_gate),
    .new_gate  (gate_new)
  );

  assign pay_in = {in_tuser, in_tlast, in_tdata[DATA_W-1:GATE_W], gate_new};

  gsub_slice #(.PAY_W(PAY_W)) u_slice (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_pay   (pay_in),
    .s_valid (in_tvalid),
    .s_ready (in_tready),
    .m_pay   (pay_out),
    .m_valid (out_tvalid),
    .m_ready (out_tready)
  );

  assign out_tdata = pay_out[DATA_W-1:0];
  assign out_tlast = pay_out[DATA_W];
  assign out_tuser = pay_out[PAY_W-1 -: USER_W];
endmodule

// File: rtl/gsub_checks.sv
module gsub_checks #(
  parameter int DATA_W = 32,
  parameter int USER_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        sel,
  input logic [1:0]        usr_gate,
  input logic [DATA_W-1:0] in_tdata,
  input logic              in_tlast,
  input logic [USER_W-1:0] in_tuser,
  input logic              in_tvalid,
  input logic              in_tready,
  input logic [DATA_W-1:0] out_tdata,
  input logic              out_tlast,
  input logic [USER_W-1:0] out_tuser,
  input logic              out_tvalid,
  input logic              out_tready,
  input logic [1:0]        ctl_bresp,
  input logic              ctl_bvalid,
  input logic [31:0]       ctl_rdata,
  input logic [1:0]        ctl_rresp,
  input logic              ctl_rvalid
);
  logic acc;
  assign acc = in_tvalid && in_tready;

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_tvalid);

  assert_gate_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == 2'b00) |=> out_tdata[1:0] == $past(in_tdata[1:0]));

  assert_gate_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == 2'b01) |=> out_tdata[1:0] == $past(usr_gate));

  assert_gate_and_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel[1]) |=> out_tdata[1:0] == ($past(in_tdata[1:0]) & $past(usr_gate)));

  assert_side_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_tvalid && out_tdata[DATA_W-1:2] == $past(in_tdata[DATA_W-1:2])
            && out_tlast == $past(in_tlast) && out_tuser == $past(in_tuser));

  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !out_tready) |=> out_tvalid && $stable(out_tdata)
            && $stable(out_tlast) && $stable(out_tuser));

  assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_tvalid && !out_tready) |-> !in_tready);

  assert_rsv_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rvalid |-> ctl_rdata[31:2] == '0);

  assert_resp_okay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_bvalid |-> ctl_bresp == 2'b00) and (ctl_rvalid |-> ctl_rresp == 2'b00));
endmodule

bind gate_sub_stage gsub_checks #(.DATA_W(DATA_W), .USER_W(USER_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel        (sel_q),
  .usr_gate   (usr_gate),
  .in_tdata   (in_tdata),
  .in_tlast   (in_tlast),
  .in_tuser   (in_tuser),
  .in_tvalid  (in_tvalid),
  .in_tready  (in_tready),
  .out_tdata  (out_tdata),
  .out_tlast  (out_tlast),
  .out_tuser  (out_tuser),
  .out_tvalid (out_tvalid),
  .out_tready (out_tready),
  .ctl_bresp  (ctl_bresp),
  .ctl_bvalid (ctl_bvalid),
  .ctl_rdata  (ctl_rdata),
  .ctl_rresp  (ctl_rresp),
  .ctl_rvalid (ctl_rvalid)
);

// File: tb/sim_gate_sub_stage.sv
module sim_gate_sub_stage;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int USER_W = 4;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] ctl_awaddr = '0, ctl_araddr = '0;
  logic ctl_awvalid = 0, ctl_wvalid = 0, ctl_arvalid = 0;
  logic ctl_bready = 1, ctl_rready = 1;
  logic [31:0] ctl_wdata = '0;
  logic [3:0]  ctl_wstrb = '0;
  logic ctl_awready, ctl_wready, ctl_bvalid, ctl_arready, ctl_rvalid;
  logic [1:0] ctl_bresp, ctl_rresp;
  logic [31:0] ctl_rdata;
  logic [1:0] usr_gate = '0;
  logic [DATA_W-1:0] in_tdata = '0;
  logic in_tlast = 0, in_tvalid = 0;
  logic [USER_W-1:0] in_tuser = '0;
  logic in_tready;
  logic [DATA_W-1:0] out_tdata;
  logic out_tlast, out_tvalid;
  logic [USER_W-1:0] out_tuser;
  logic out_tready = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_sub_stage #(.DATA_W(DATA_W), .USER_W(USER_W), .ADDR_W(ADDR_W)) u0 (.*);

  typedef struct packed {
    logic [USER_W-1:0] user;
    logic              last;
    logic [DATA_W-1:0] data;
  } beat_t;

  beat_t expq[$];
  int checks = 0, errors = 0, sent = 0, got = 0;
  bit bp_on = 0, hold_out = 0;
  logic [1:0] sel_m = 2'b00;
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] nxt(inout logic [31:0] s);
    s = s * 32'd1103515245 + 32'd12345;
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic ctl_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    ctl_awaddr = a; ctl_wdata = d; ctl_wstrb = s;
    ctl_awvalid = 1; ctl_wvalid = 1;
    #1;
    while (!(ctl_awready && ctl_wready)) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ctl_awvalid = 0; ctl_wvalid = 0;
    while (!ctl_bvalid) begin @(negedge clk); #1; end
    check(ctl_bresp == 2'b00, "R8 write response", ctl_bresp, 0);
    @(posedge clk); #1;
  endtask

  task automatic ctl_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    ctl_araddr = a; ctl_arvalid = 1;
    #1;
    while (!ctl_arready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ctl_arvalid = 0;
    while (!ctl_rvalid) begin @(negedge clk); #1; end
    check(ctl_rresp == 2'b00, "R8 read response", ctl_rresp, 0);
    d = ctl_rdata;
    @(posedge clk); #1;
  endtask

  // driver: junk on usr_gate while waiting (R10), pushes the expected beat at acceptance
  task automatic send(input logic [DATA_W-1:0] d, input logic l, input logic [USER_W-1:0] u, input logic [1:0] ug);
    beat_t e;
    in_tdata = d; in_tlast = l; in_tuser = u;
    forever begin
      @(negedge clk);
      in_tvalid = 1;
      usr_gate = ~ug;
      #1;
      if (in_tready) break;
    end
    usr_gate = ug;
    e.data = d; e.last = l; e.user = u;
    case (sel_m)
      2'b00:   e.data[1:0] = d[1:0];
      2'b01:   e.data[1:0] = ug;
      default: e.data[1:0] = d[1:0] & ug;
    endcase
    expq.push_back(e);
    sent++;
    @(posedge clk); #1;
    in_tvalid = 0;
  endtask

  task automatic send_burst(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] r;
      r = nxt(seed);
      send(r, r[31], r[7:4], r[9:8]);
    end
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: pops and compares each beat that leaves
  initial begin
    forever begin
      @(negedge clk);
      if (hold_out) out_tready = 0;
      else if (bp_on) out_tready = nxt(seed) >> 31;
      else out_tready = 1;
      #2;
      if (rst_n && out_tvalid && out_tready) begin
        beat_t e, a;
        a.data = out_tdata; a.last = out_tlast; a.user = out_tuser;
        got++;
        if (expq.size() == 0) begin
          check(0, "R6 unexpected beat", a, 0);
        end else begin
          e = expq.pop_front();
          check(a.data[1:0] == e.data[1:0], "R2/R3/R4/R9/R10 gate bits", a.data[1:0], e.data[1:0]);
          check(a == e, "R5 data, last, user carried", a, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual hung expected completion");
    finish_sim();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check(out_tvalid == 0, "R1 output empty after reset", out_tvalid, 0);
    ctl_read(4'h0, rd);
    check(rd == 0, "R1 mode resets to 00", rd, 0);

    // R2 pass-through gate
    send_burst(8);
    drain();

    // R3 user gate, with back-pressure
    ctl_write(4'h0, 32'h1, 4'hF); sel_m = 2'b01;
    ctl_read(4'h0, rd);
    check(rd == 32'h1, "R7 read back mode 01", rd, 1);
    bp_on = 1;
    send_burst(10);
    drain();

    // R4 AND, both encodings
    ctl_write(4'h0, 32'h2, 4'hF); sel_m = 2'b10;
    send_burst(8);
    drain();
    ctl_write(4'h0, 32'h3, 4'hF); sel_m = 2'b11;
    send_burst(8);
    drain();
    bp_on = 0;

    // R7 reserved bits and strobe
    ctl_write(4'h0, 32'hFFFF_FFFE, 4'hF); sel_m = 2'b10;
    ctl_read(4'h0, rd);
    check(rd == 32'h2, "R7 reserved bits read zero", rd, 2);
    ctl_write(4'h0, 32'h1, 4'h0);
    ctl_read(4'h0, rd);
    check(rd == 32'h2, "R7 write without strobe ignored", rd, 2);

    // R8 other offsets
    ctl_write(4'h4, 32'h0, 4'hF);
    ctl_read(4'h0, rd);
    check(rd == 32'h2, "R8 write to other offset ignored", rd, 2);
    ctl_read(4'h8, rd);
    check(rd == 32'h0, "R8 other offset reads zero", rd, 0);
    ctl_write(4'h0, 32'h0, 4'hF); sel_m = 2'b00;

    // R9 / R10: beat parked in output keeps old gate; next beat uses new mode
    hold_out = 1;
    send(32'hA5A5_0003, 1'b1, 4'h9, 2'b00);
    @(negedge clk); #2;
    check(out_tvalid == 1, "R6 beat held while stalled", out_tvalid, 1);
    check(in_tready == 0, "R6 ready low when full and stalled", in_tready, 0);
    fork
      send(32'h5A5A_0002, 1'b0, 4'h6, 2'b01);
      begin
        ctl_write(4'h0, 32'h1, 4'hF);
        sel_m = 2'b01;
        repeat (2) @(negedge clk);
        hold_out = 0;
      end
    join
    drain();

    check(sent == got && expq.size() == 0, "R6 no beat lost or repeated", got, sent);
    finish_sim();
  end
endmodule